// File: doc/BRIEF.md
# Main/Side Road Signal Sequencer

This block controls the signals at a crossing between a busy main road and a lightly used side road that has a vehicle detector. The main road shows green for as long as the detector reports no waiting vehicle. Once a vehicle is seen, the main road keeps green for a guaranteed minimum time. It then hands right of way to the side road for a fixed green period, and afterwards returns to main green whether or not the detector is still active.

All timing is counted in periods of a one-cycle, once-per-second strobe supplied by the system. Each road has its own lamp register. Yellow is therefore shown only on the road that is giving up green, and the road about to receive green stays red until the other road is fully red. The phase timer is cleared at every phase change, so each new main green after a detection again lasts the whole minimum.

Top module: `road_priority_signal`

## Requirements
- R1: A synchronous reset sets the main lamp to green, the side lamp to red and the phase timer to zero. The first detection after reset then waits the full main minimum.
- R2: Each lamp output uses 2'b00 for green, 2'b01 for yellow and 2'b11 for red. The code 2'b10 never appears.
- R3: While the sensor is low during main green, the main lamp stays green and the side lamp stays red for any number of ticks.
- R4: In main green, only ticks sampled with the sensor high are counted. On the MAIN_TICKS-th such tick (default 40), the main lamp turns yellow and the side lamp stays red.
- R5: If the sensor drops during main green, the counted ticks are kept and not cleared. Counting resumes from the kept value when the sensor rises again.
- R6: Main yellow lasts AMBER_TICKS ticks (default 4) with the side lamp red. On the last of these ticks the main lamp turns red and the side lamp turns green in the same cycle.
- R7: Side green lasts SIDE_TICKS ticks (default 20) whatever the sensor shows. Side yellow then lasts AMBER_TICKS ticks with the main lamp red, after which the lamps return to main green and side red.
- R8: The timer is cleared at every phase end. With the sensor held high, the next main green lasts the full MAIN_TICKS ticks.
- R9: The two lamps are never both non-red in the same cycle.
- R10: The lamps change only in the cycle after a tick strobe is sampled. Clock cycles without a tick leave both lamps unchanged.
- R11: A lamp turns yellow only directly from green on the same road.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick1s | input | 1 | One-cycle strobe, once per second |
| sideSensor | input | 1 | Side-road vehicle detector, high when a vehicle is waiting |
| mainLamp | output | 2 | Main-road lamp code |
| sideLamp | output | 2 | Side-road lamp code |

## Verification
The hardest case to reach from the ports is a sensor that drops partway through the main-green minimum and rises again. The only sign that the count was held rather than cleared is how many further qualifying ticks pass before yellow appears. The stimulus counts 25 qualifying ticks, then gives 30 ticks with the sensor low, then expects yellow on exactly the 15th qualifying tick after that. A second full cycle with the sensor held high, including through side green, shows that the timer is cleared between phases and that side green ends regardless of the detector.

// File: rtl/rps_pkg.sv
package rps_pkg;

  typedef enum logic [1:0] {
    LAMP_GO      = 2'b00,
    LAMP_CAUTION = 2'b01,
    LAMP_STOP    = 2'b11
  } lamp_t;

  typedef enum logic [1:0] {
    PH_MAIN_GO,
    PH_MAIN_CAUTION,
    PH_SIDE_GO,
    PH_SIDE_CAUTION
  } phase_t;

  // strobes from the sequencer to the phase timer
  typedef struct packed {
    logic advance;
    logic restart;
  } tmr_cmd_t;

endpackage

// File: rtl/rps_phase_timer.sv
module rps_phase_timer #(
  parameter int CNT_W = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  rps_pkg::tmr_cmd_t    cmd,
  output logic [CNT_W-1:0]     count
);

  // restart wins over advance so a phase end always leaves zero
  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (cmd.restart) begin
      count <= '0;
    end else if (cmd.advance) begin
      count <= count + 1'b1;
    end
  end

endmodule

// File: rtl/rps_sequencer.sv
module rps_sequencer
  import rps_pkg::*;
#(
  parameter int MAIN_TICKS  = 40,
  parameter int SIDE_TICKS  = 20,
  parameter int AMBER_TICKS = 4,
  parameter int CNT_W       = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick1s,
  input  logic             sideSensor,
  input  logic [CNT_W-1:0] count,
  output tmr_cmd_t         cmd,
  output lamp_t            mainLamp,
  output lamp_t            sideLamp
);

  localparam logic [CNT_W-1:0] MainLast  = CNT_W'(MAIN_TICKS - 1);
  localparam logic [CNT_W-1:0] SideLast  = CNT_W'(SIDE_TICKS - 1);
  localparam logic [CNT_W-1:0] AmberLast = CNT_W'(AMBER_TICKS - 1);

  phase_t phase, phaseNext;
  logic   qualTick;
  logic   phaseEnd;
  logic [CNT_W-1:0] lastCount;
  lamp_t  mainNext, sideNext;

  always_comb begin
    unique case (phase)
      PH_MAIN_GO:      lastCount = MainLast;
      PH_SIDE_GO:      lastCount = SideLast;
      default:         lastCount = AmberLast;
    endcase
  end

  // in main green only sensor-qualified ticks count; elsewhere every tick
  assign qualTick = tick1s && ((phase != PH_MAIN_GO) || sideSensor);
  assign phaseEnd = qualTick && (count == lastCount);

  assign cmd.advance = qualTick && !phaseEnd;
  assign cmd.restart = phaseEnd;

  always_comb begin
    unique case (phase)
      PH_MAIN_GO:      phaseNext = PH_MAIN_CAUTION;
      PH_MAIN_CAUTION: phaseNext = PH_SIDE_GO;
      PH_SIDE_GO:      phaseNext = PH_SIDE_CAUTION;
      default:         phaseNext = PH_MAIN_GO;
    endcase
  end

  // each road's lamp is derived separately from the phase being entered
  always_comb begin
    mainNext = mainLamp;
    sideNext = sideLamp;
    if (phaseEnd) begin
      unique case (phaseNext)
        PH_MAIN_GO:      begin mainNext = LAMP_GO;      sideNext = LAMP_STOP;    end
        PH_MAIN_CAUTION: begin mainNext = LAMP_CAUTION; sideNext = LAMP_STOP;    end
        PH_SIDE_GO:      begin mainNext = LAMP_STOP;    sideNext = LAMP_GO;      end
        default:         begin mainNext = LAMP_STOP;    sideNext = LAMP_CAUTION; end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_MAIN_GO;
      mainLamp <= LAMP_GO;
      sideLamp <= LAMP_STOP;
    end else begin
      if (phaseEnd) phase <= phaseNext;
      mainLamp <= mainNext;
      sideLamp <= sideNext;
    end
  end

endmodule

// File: rtl/road_priority_signal.sv
module road_priority_signal #(
  parameter int MAIN_TICKS  = 40,
  parameter int SIDE_TICKS  = 20,
  parameter int AMBER_TICKS = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick1s,
  input  logic       sideSensor,
  output logic [1:0] mainLamp,
  output logic [1:0] sideLamp
);

  localparam int LongestPhase = (MAIN_TICKS > SIDE_TICKS) ?
                                ((MAIN_TICKS > AMBER_TICKS) ? MAIN_TICKS : AMBER_TICKS) :
                                ((SIDE_TICKS > AMBER_TICKS) ? SIDE_TICKS : AMBER_TICKS);
  localparam int CntW = (LongestPhase < 2) ? 1 : $clog2(LongestPhase);

  rps_pkg::tmr_cmd_t timerCmd;
  logic [CntW-1:0]   phaseCount;
  rps_pkg::lamp_t    mainLampQ, sideLampQ;

  rps_sequencer #(
    .MAIN_TICKS (MAIN_TICKS),
    .SIDE_TICKS (SIDE_TICKS),
    .AMBER_TICKS(AMBER_TICKS),
    .CNT_W      (CntW)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .tick1s    (tick1s),
    .sideSensor(sideSensor),
    .count     (phaseCount),
    .cmd       (timerCmd),
    .mainLamp  (mainLampQ),
    .sideLamp  (sideLampQ)
  );

  rps_phase_timer #(
    .CNT_W(CntW)
  ) u_timer (
    .clk  (clk),
    .rst  (rst),
    .cmd  (timerCmd),
    .count(phaseCount)
  );

  assign mainLamp = mainLampQ;
  assign sideLamp = sideLampQ;

endmodule

// File: rtl/rps_checker.sv
module rps_checker (
  input logic       clk,
  input logic       rst,
  input logic       tick1s,
  input logic       sideSensor,
  input logic [1:0] mainLamp,
  input logic [1:0] sideLamp
);

  localparam logic [1:0] Grn = 2'b00;
  localparam logic [1:0] Yel = 2'b01;
  localparam logic [1:0] Red = 2'b11;

  p_exclusive_r9: assert property (@(posedge clk) disable iff (rst)
    (mainLamp == Red) || (sideLamp == Red));

  p_legal_code_r2: assert property (@(posedge clk) disable iff (rst)
    (mainLamp != 2'b10) && (sideLamp != 2'b10));

  p_hold_no_tick_r10: assert property (@(posedge clk) disable iff (rst)
    !tick1s |=> ($stable(mainLamp) && $stable(sideLamp)));

  p_main_yel_from_grn_r11: assert property (@(posedge clk) disable iff (rst)
    (mainLamp != Yel) |=> ((mainLamp != Yel) || ($past(mainLamp) == Grn)));

  p_side_yel_from_grn_r11: assert property (@(posedge clk) disable iff (rst)
    (sideLamp != Yel) |=> ((sideLamp != Yel) || ($past(sideLamp) == Grn)));

  p_idle_main_r3: assert property (@(posedge clk) disable iff (rst)
    ((mainLamp == Grn) && !sideSensor) |=> (mainLamp == Grn) && (sideLamp == Red));

  p_side_waits_r6: assert property (@(posedge clk) disable iff (rst)
    (mainLamp == Yel) |=> (sideLamp == Red) || (sideLamp == Grn && mainLamp == Red));

endmodule

bind road_priority_signal rps_checker u_chk (.*);

// File: tb/road_priority_signal_bench.sv
module road_priority_signal_bench;

  localparam int MainT  = 40;
  localparam int SideT  = 20;
  localparam int AmberT = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick1s = 1'b0;
  logic sideSensor = 1'b0;
  logic [1:0] mainLamp, sideLamp;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [3:0] expQ[$];
  string      tagQ[$];

  int expPh = 0;
  int elapsed = 0;

  always #10 clk = ~clk;

  road_priority_signal #(
    .MAIN_TICKS(MainT), .SIDE_TICKS(SideT), .AMBER_TICKS(AmberT)
  ) u_road_priority_signal (
    .clk(clk), .rst(rst), .tick1s(tick1s), .sideSensor(sideSensor),
    .mainLamp(mainLamp), .sideLamp(sideLamp)
  );

  // lamp codes per R2: green 00, yellow 01, red 11
  function automatic logic [3:0] lampsOf(int ph);
    case (ph)
      0: return {2'b00, 2'b11};
      1: return {2'b01, 2'b11};
      2: return {2'b11, 2'b00};
      default: return {2'b11, 2'b01};
    endcase
  endfunction

  function automatic void modelTick();
    if (expPh == 0) begin
      if (sideSensor) begin
        elapsed++;
        if (elapsed == MainT) begin expPh = 1; elapsed = 0; end
      end
    end else begin
      elapsed++;
      if ((expPh == 2 && elapsed == SideT) || (expPh != 2 && elapsed == AmberT)) begin
        expPh = (expPh + 1) % 4;
        elapsed = 0;
      end
    end
  endfunction

  // driver: one clock cycle, with or without tick; pushes expected lamps
  task automatic stepCycle(input logic t, input string tag);
    @(negedge clk);
    tick1s = t;
    @(posedge clk);
    if (t) modelTick();
    #1;
    expQ.push_back(lampsOf(expPh));
    tagQ.push_back(tag);
  endtask

  task automatic ticks(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      stepCycle(1'b1, tag);
      stepCycle(1'b0, tag);
    end
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) stepCycle(1'b0, tag);
  endtask

  task automatic doReset(input string tag);
    @(negedge clk);
    rst = 1'b1;
    tick1s = 1'b0;
    @(posedge clk);
    expPh = 0;
    elapsed = 0;
    #1;
    expQ.push_back(lampsOf(0));
    tagQ.push_back(tag);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // monitor: compare design outputs with the queue, away from the edge
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      logic [3:0] e;
      string tg;
      e  = expQ.pop_front();
      tg = tagQ.pop_front();
      checks++;
      if ({mainLamp, sideLamp} !== e) begin
        fails++;
        $display("FAIL %s: main/side actual %b/%b expected %b/%b",
                 tg, mainLamp, sideLamp, e[3:2], e[1:0]);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    doReset("R1 reset lamps");
    idle(3, "R10 no tick after reset");

    sideSensor = 1'b0;
    ticks(50, "R3 sensor low keeps main green");

    sideSensor = 1'b1;
    ticks(MainT - 1, "R4 main green before minimum");
    idle(5, "R10 no tick holds lamps");
    ticks(1, "R4 main yellow on last counted tick");
    ticks(AmberT - 1, "R6 main yellow side red");
    ticks(1, "R6 side green after yellow");
    sideSensor = 1'b0;
    ticks(SideT - 1, "R7 side green ignores sensor");
    ticks(1, "R7 side yellow main red");
    ticks(AmberT, "R7 back to main green");

    // count held across a sensor drop
    sideSensor = 1'b1;
    ticks(25, "R5 first part of minimum");
    sideSensor = 1'b0;
    ticks(30, "R5 sensor low holds count");
    sideSensor = 1'b1;
    ticks(14, "R5 resumed count not yet done");
    ticks(1, "R5 yellow after resumed count");
    ticks(AmberT + SideT + AmberT, "R7 full handover with sensor high");

    // timer cleared: full minimum again with sensor held high
    ticks(MainT - 1, "R8 cleared timer full minimum");
    ticks(1, "R8 yellow at full minimum");
    ticks(AmberT + 5, "R6 into side green");

    doReset("R1 reset mid side green");
    ticks(MainT - 1, "R1 full minimum after reset");
    ticks(1, "R1 yellow after full minimum");
    ticks(AmberT + SideT + AmberT + 2, "R9 R11 sequence completes");
    idle(2, "R10 final idle");
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    @(negedge clk);
    @(negedge clk);
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule